// File: doc/BRIEF.md
# Dual-Half LCD Scan Timing Generator

This block drives the column and row drivers of a dot-matrix liquid crystal panel. It takes a programmed line width in dots, a line count and a single/dual selection. From these it produces a nibble shift clock, a line latch pulse, a first-line marker and an alternating drive-polarity signal, plus two 4-bit data buses. The upper bus feeds the top half of the glass and the lower bus feeds the bottom half. In single mode the whole screen hangs off the upper bus.

Pixel data comes from an upstream source as 8-bit words over a ready/valid handshake.
- In single mode one word supplies two consecutive nibbles on the upper bus, bits [3:0] first and then bits [7:4].
- In dual mode one word supplies one shift: bits [3:0] go to the upper half and bits [7:4] go to the lower half of the same line index.

When no word is offered, the shift clock simply waits. Configuration inputs are expected to be held steady and are changed only while reset is asserted.

Top module: `lcd_scan_timer`

## Requirements
- R1: While `rst_n` is low, all outputs, including `pix_ready`, are 0. In the first clock cycle after release a frame starts: `first_line` and `ac_pol` both read 1 and `pix_ready` is 1.
- R2: Each shift pulse on `shift_clk` is exactly one clock cycle high, and `up_nib`/`dn_nib` are stable while it is high. A line consists of exactly `cfg_width`/4 shift pulses, with `cfg_width` a nonzero multiple of 4.
- R3: In single mode (`cfg_dual`=0) each accepted word produces two shifts on `up_nib`, first bits [3:0] and then bits [7:4]. `dn_nib` stays 0.
- R4: In dual mode (`cfg_dual`=1) each accepted word produces one shift, with bits [3:0] on `up_nib` and bits [7:4] on `dn_nib`.
- R5: While `pix_ready` is 1 and `pix_valid` is 0, no shift pulse occurs and the nibble buses hold their values.
- R6: After the last shift of a line, `line_latch` goes high for exactly two clock cycles, and `shift_clk` is low throughout.
- R7: A frame has `cfg_height` lines in single mode and `cfg_height`/2 lines in dual mode. `first_line` is 1 from the start of each frame through the latch of line 0, and 0 during the other lines.
- R8: `ac_pol` changes state exactly in the cycles where `first_line` rises, so it toggles once per frame, including a one-line frame.
- R9: `pix_ready` is never 1 while `line_latch` is high.
- R10: A reset asserted mid-line clears the scan position and any half-used word. After release, the next accepted word's bits [3:0] are the first nibble shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears counters and outputs |
| cfg_dual | input | 1 | 1 = screen split into two halves |
| cfg_width | input | DOT_W | Line width in dots, multiple of 4 |
| cfg_height | input | LINE_W | Screen height in lines |
| pix_data | input | 8 | Pixel word from upstream |
| pix_valid | input | 1 | Pixel word valid |
| pix_ready | output | 1 | Block wants a pixel word this cycle |
| up_nib | output | 4 | Upper-half (or only) panel data |
| dn_nib | output | 4 | Lower-half panel data |
| shift_clk | output | 1 | Nibble shift clock |
| line_latch | output | 1 | Line latch pulse |
| first_line | output | 1 | First-line marker |
| ac_pol | output | 1 | Drive polarity, alternates per frame |

## Verification
The bench keeps the default widths (DOT_W=13, LINE_W=11) so that the full 4096-dot by 1024-line range is representable. It programs small geometries so that many line and frame boundaries fall within a short run:
- a 16-dot, 3-line single screen, where words straddle line ends;
- an 8-dot, 4-line dual screen, with two lines per half;
- a 4-dot, 1-line static screen, where every line is also a frame and half of each word spills into the next frame.

The static case, together with a reset issued while a half-used word is held, exercises the polarity toggle and buffer clearing at their extremes.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int DOT_W  = 13,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dual,
  input  logic [DOT_W-1:0]  cfg_width,
  input  logic [LINE_W-1:0] cfg_height,
  input  logic [7:0]        pix_data,
  input  logic              pix_valid,
  output logic              pix_ready,
  output logic [3:0]        up_nib,
  output logic [3:0]        dn_nib,
  output logic              shift_clk,
  output logic              line_latch,
  output logic              first_line,
  output logic              ac_pol
);
  localparam int NIB_DOTS = 4;

  typedef enum logic [1:0] {S_FRAME, S_DATA, S_LATCH} st_t;

  st_t               st;
  logic              ph;
  logic              hold_v;
  logic [3:0]        hold_nib;
  logic [1:0]        lat_cnt;
  logic [DOT_W-1:0]  dot_cnt;
  logic [LINE_W-1:0] line_idx;

  wire [LINE_W-1:0] lines_pf  = cfg_dual ? (cfg_height >> 1) : cfg_height;
  wire              last_nib  = ({1'b0, dot_cnt} + (DOT_W+1)'(NIB_DOTS)) >= {1'b0, cfg_width};
  wire              last_line = ({1'b0, line_idx} + 1'b1) >= {1'b0, lines_pf};

  assign pix_ready  = (st == S_DATA) && !ph && (cfg_dual || !hold_v);
  wire   take       = pix_ready && pix_valid;
  wire   slot_go    = take || (hold_v && !cfg_dual);
  assign first_line = (st != S_FRAME) && (line_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_FRAME;
      ph         <= 1'b0;
      hold_v     <= 1'b0;
      hold_nib   <= '0;
      lat_cnt    <= '0;
      dot_cnt    <= '0;
      line_idx   <= '0;
      up_nib     <= '0;
      dn_nib     <= '0;
      shift_clk  <= 1'b0;
      line_latch <= 1'b0;
      ac_pol     <= 1'b0;
    end else begin
      shift_clk <= 1'b0;
      case (st)
        S_FRAME: begin
          st       <= S_DATA;
          ac_pol   <= ~ac_pol;
          line_idx <= '0;
          dot_cnt  <= '0;
          ph       <= 1'b0;
        end
        S_DATA: begin
          if (!ph) begin
            if (slot_go) begin
              ph <= 1'b1;
              if (cfg_dual) begin
                up_nib <= pix_data[3:0];
                dn_nib <= pix_data[7:4];
              end else if (hold_v) begin
                up_nib <= hold_nib;
                hold_v <= 1'b0;
              end else begin
                up_nib   <= pix_data[3:0];
                hold_nib <= pix_data[7:4];
                hold_v   <= 1'b1;
              end
            end
          end else begin
            ph        <= 1'b0;
            shift_clk <= 1'b1;
            if (last_nib) begin
              st      <= S_LATCH;
              lat_cnt <= '0;
              dot_cnt <= '0;
            end else begin
              dot_cnt <= dot_cnt + DOT_W'(NIB_DOTS);
            end
          end
        end
        default: begin
          case (lat_cnt)
            2'd0: begin
              line_latch <= 1'b1;
              lat_cnt    <= 2'd1;
            end
            2'd1: lat_cnt <= 2'd2;
            default: begin
              line_latch <= 1'b0;
              lat_cnt    <= '0;
              if (last_line) begin
                st       <= S_FRAME;
                line_idx <= '0;
              end else begin
                st       <= S_DATA;
                line_idx <= line_idx + 1'b1;
              end
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_dual,
  input logic       pix_valid,
  input logic       pix_ready,
  input logic [3:0] up_nib,
  input logic [3:0] dn_nib,
  input logic       shift_clk,
  input logic       line_latch,
  input logic       first_line,
  input logic       ac_pol
);
  AST_SHIFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |=> !shift_clk); // R2
  AST_NIB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |-> ($stable(up_nib) && $stable(dn_nib))); // R2
  AST_SINGLE_DN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dual |-> (dn_nib == 4'd0)); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> ($stable(up_nib) && $stable(dn_nib))); // R5
  AST_NO_SHIFT_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    line_latch |-> !shift_clk); // R6
  AST_LATCH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_latch) |-> $past(line_latch, 2)); // R6
  AST_LATCH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_latch) |=> line_latch); // R6
  AST_AC_ON_FLM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(first_line) |-> (ac_pol != $past(ac_pol))); // R8
  AST_AC_ONLY_FLM: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_pol != $past(ac_pol)) |-> $rose(first_line)); // R8
  AST_READY_NOT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> !line_latch); // R9
endmodule

bind lcd_scan_timer lcd_scan_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .pix_valid(pix_valid),
  .pix_ready(pix_ready), .up_nib(up_nib), .dn_nib(dn_nib),
  .shift_clk(shift_clk), .line_latch(line_latch),
  .first_line(first_line), .ac_pol(ac_pol)
);

// File: tb/tb_lcd_scan_timer.sv
module tb_lcd_scan_timer;
  localparam int DOT_W  = 13;
  localparam int LINE_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dual = 1'b0;
  logic [DOT_W-1:0] cfg_width = 13'd16;
  logic [LINE_W-1:0] cfg_height = 11'd3;
  logic [7:0] pix_data = '0;
  logic pix_valid = 1'b0;
  logic pix_ready;
  logic [3:0] up_nib, dn_nib;
  logic shift_clk, line_latch, first_line, ac_pol;

  always #4 clk = ~clk;

  lcd_scan_timer #(.DOT_W(DOT_W), .LINE_W(LINE_W)) dut (.*);

  int checks = 0;
  int errors = 0;
  logic [7:0] expq[$];
  int lpf = 3;
  int npl = 4;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor
  logic prev_sck, prev_lat, prev_fl, prev_ac;
  int pulses, line_no, lat_len, lines_done, toggles;
  always @(negedge clk) begin
    if (!rst_n) begin
      pulses = 0; line_no = 0; lat_len = 0; lines_done = 0; toggles = 0;
    end else begin
      if (shift_clk && !prev_sck) begin
        if (expq.size() == 0) check(1'b0, "R3/R4 unexpected shift", {up_nib, dn_nib}, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          check({up_nib, dn_nib} == e, "R3/R4 nibble pair", {up_nib, dn_nib}, e);
        end
        pulses++;
      end
      if (pix_ready) check(!line_latch, "R9 ready during latch", line_latch, 0);
      if (line_latch && !prev_lat) begin
        check(pulses == npl, "R2 shifts per line", pulses, npl);
        check(first_line == (line_no == 0), "R7 first_line at latch", first_line, line_no == 0);
        pulses = 0; lat_len = 0;
        line_no = (line_no + 1) % lpf;
        lines_done++;
      end
      if (line_latch) begin
        lat_len++;
        check(!shift_clk, "R6 shift during latch", shift_clk, 0);
      end
      if (!line_latch && prev_lat) check(lat_len == 2, "R6 latch length", lat_len, 2);
      if (ac_pol != prev_ac) begin
        toggles++;
        check(first_line && !prev_fl, "R8 ac toggle without frame start", first_line, 1);
      end
      if (first_line && !prev_fl) check(ac_pol != prev_ac, "R8 frame start without toggle", ac_pol, !prev_ac);
    end
    prev_sck = shift_clk; prev_lat = line_latch; prev_fl = first_line; prev_ac = ac_pol;
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [7:0] w);
    @(negedge clk);
    pix_data = w; pix_valid = 1'b1;
    while (!pix_ready) @(negedge clk);
    if (cfg_dual) expq.push_back({w[3:0], w[7:4]});
    else begin
      expq.push_back({w[3:0], 4'h0});
      expq.push_back({w[7:4], 4'h0});
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    pix_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic do_reset(input logic dual, input int width, input int height);
    @(negedge clk);
    rst_n = 1'b0; pix_valid = 1'b0;
    expq.delete();
    repeat (3) @(negedge clk);
    check({pix_ready, up_nib, dn_nib, shift_clk, line_latch, first_line, ac_pol} == 0,
          "R1 outputs in reset", {pix_ready, up_nib, dn_nib, shift_clk, line_latch, first_line, ac_pol}, 0);
    cfg_dual = dual; cfg_width = DOT_W'(width); cfg_height = LINE_W'(height);
    lpf = dual ? height / 2 : height;
    npl = width / 4;
    rst_n = 1'b1;
    @(negedge clk);
    check(first_line && ac_pol && pix_ready, "R1 frame start after release",
          {first_line, ac_pol, pix_ready}, 7);
  endtask

  task automatic drain();
    int n = 0;
    while (expq.size() != 0 && n < 1000) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    check(expq.size() == 0, "R3/R4 all nibbles shifted", expq.size(), 0);
  endtask

  function automatic logic [7:0] wgen(input int i);
    return 8'(i * 59 + 81);
  endfunction

  initial begin
    logic [3:0] held;
    // single, 16 dots, 3 lines
    do_reset(1'b0, 16, 3);
    for (int i = 0; i < 3; i++) send(wgen(i));
    idle(6);
    held = up_nib;
    repeat (6) @(negedge clk);
    check(!shift_clk && pix_ready, "R5 stalled with no pulse", {shift_clk, pix_ready}, 1);
    check(up_nib == held, "R5 nibble held during stall", up_nib, held);
    for (int i = 3; i < 12; i++) send(wgen(i));
    idle(1);
    drain();
    check(lines_done == 6, "R2 lines in single run", lines_done, 6);
    check(toggles == 3, "R7 frames of 3 lines", toggles, 3);

    // dual, 8 dots, 4 lines -> 2 lines per frame
    do_reset(1'b1, 8, 4);
    for (int i = 0; i < 4; i++) send(wgen(i + 20));
    idle(5);
    for (int i = 4; i < 8; i++) send(wgen(i + 20));
    idle(1);
    drain();
    check(lines_done == 4, "R4 lines in dual run", lines_done, 4);
    check(toggles == 3, "R7 dual frame of height/2", toggles, 3);

    // static: single, 4 dots, 1 line
    do_reset(1'b0, 4, 1);
    for (int i = 0; i < 3; i++) send(wgen(i + 40));
    idle(1);
    drain();
    check(lines_done == 6, "R2 one shift per static line", lines_done, 6);
    check(toggles == 7, "R8 toggle every static frame", toggles, 7);

    // mid-line reset with a held nibble
    send(8'hC5);
    idle(3);
    do_reset(1'b0, 4, 1);
    send(8'h9A);
    send(8'h36);
    idle(1);
    drain();
    check(lines_done == 4, "R10 clean restart line count", lines_done, 4);
    check(toggles == 5, "R10 clean restart frames", toggles, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule